// File: doc/BRIEF.md
# Full-Map Directory Invalidation Controller

This block is the memory-side directory engine for a single cache block shared by a small group of processors (four by default). It keeps one presence bit per cache and an exclusive flag. A read request adds the reader to the presence vector. A write request starts an invalidation round. Every other cache marked present receives an invalidate that carries the writer's ID, so each of those caches can acknowledge directly to the writer.

When it accepts a write, the engine issues a write-reply to the writer. The reply carries the number of acknowledgements the writer must collect. The engine sees the acknowledgements on its own input port as they travel to the writer. It grants exclusive ownership only once every expected acknowledgement has arrived. At that point the presence vector holds the writer's bit alone and the exclusive flag is set. While a round is open the engine refuses new requests.

Top module: `dir_inval_ctrl`

## Requirements
- R1: After reset the presence vector is all zeros, the exclusive flag is 0, req_busy is 0, and inv_valid, wr_reply_valid and grant_valid are 0.
- R2: A read request (req_write=0) accepted while not busy sets bit req_id of the presence vector, keeps all other bits and clears the exclusive flag, visible one cycle after the accepting edge.
- R3: On an accepted write, for exactly one cycle starting the cycle after acceptance, inv_valid equals the presence vector with bit req_id cleared and inv_req_id equals req_id. The writer never receives an invalidate.
- R4: Alongside that cycle, wr_reply_valid pulses for one cycle with wr_reply_id equal to the writer and wr_reply_acks equal to the number of caches invalidated.
- R5: While acknowledgements are outstanding, req_busy is 1. Read and write requests are refused and leave the presence vector unchanged.
- R6: Acknowledgements (ack_valid bit i means cache i has acknowledged) from caches that were not invalidated, or repeated ones, are ignored. No grant occurs until every invalidated cache has acknowledged.
- R7: One cycle after the edge that captures the last outstanding acknowledgement, grant_valid pulses with grant_id equal to the writer. The presence vector then holds only the writer's bit, the exclusive flag is 1 and req_busy is 0.
- R8: A write with no other sharer sends no invalidate. It returns wr_reply_acks=0 and raises grant_valid in the same cycle as the write-reply, with presence set to the writer alone and the exclusive flag set.

Ports follow the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_id | input | 2 | Requesting processor |
| req_busy | output | 1 | Invalidation round open; requests refused |
| inv_valid | output | 4 | Per-cache invalidate pulse |
| inv_req_id | output | 2 | Writer ID carried by the invalidates |
| ack_valid | input | 4 | Per-cache acknowledgement observed |
| wr_reply_valid | output | 1 | Write-reply pulse to the writer |
| wr_reply_id | output | 2 | Writer addressed by the write-reply |
| wr_reply_acks | output | 3 | Number of acknowledgements to expect |
| grant_valid | output | 1 | Exclusive ownership granted |
| grant_id | output | 2 | Processor receiving ownership |
| presence | output | 4 | Presence bit per cache |
| exclusive | output | 1 | Block held exclusively |

## Verification
A corrupted outstanding-acknowledgement mask shows up at the ports in one of two ways. The grant fires before the last real acknowledgement arrives, or it never fires and req_busy stays high. Either is visible within a cycle of the acknowledgement that should have closed the round. A wrong presence vector appears directly on the presence port one cycle after the request. It also appears in the next write's invalidate set and acknowledgement count. The bench therefore checks invalidate targets, reply counts and grant timing against the sharers it built up itself through reads.

// File: rtl/dir_pkg.sv
// Shared types and helpers for the directory invalidation controller.
// Assumes a small processor count (popcount is an unrolled loop).
package dir_pkg;

    typedef enum logic {
        DIR_IDLE    = 1'b0,
        DIR_COLLECT = 1'b1
    } dir_state_e;

endpackage

// File: rtl/dir_target_calc.sv
// Computes the set of caches to invalidate for a write by `wid` and the
// number of acknowledgements that set implies. Purely combinational.
// Assumes `wid` is below N_PROC.
module dir_target_calc #(
    parameter int N_PROC = 4,
    parameter int ID_W   = 2,
    parameter int CNT_W  = 3
) (
    input  logic [N_PROC-1:0] pres,
    input  logic [ID_W-1:0]   wid,
    output logic [N_PROC-1:0] targets,
    output logic [CNT_W-1:0]  count
);
    localparam logic [N_PROC-1:0] ONE = N_PROC'(1);

    // Drop the writer's own bit from the sharer set.
    always_comb targets = pres & ~(ONE << wid);

    // Count the remaining sharers.
    always_comb begin
        count = '0;
        for (int i = 0; i < N_PROC; i++) begin
            count = count + CNT_W'(targets[i]);
        end
    end
endmodule

// File: rtl/dir_ack_tracker.sv
// Holds the mask of caches whose acknowledgement is still outstanding.
// A load replaces the mask; otherwise each ack clears its own bit, and
// acks for bits already clear have no effect.
module dir_ack_tracker #(
    parameter int N_PROC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [N_PROC-1:0] load_mask,
    input  logic [N_PROC-1:0] ack,
    output logic [N_PROC-1:0] pending,
    output logic              last_ack
);
    // Outstanding mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= '0;
        else if (load) pending <= load_mask;
        else           pending <= pending & ~ack;
    end

    // High when this cycle's acks close the last outstanding bit.
    always_comb last_ack = (|pending) && ((pending & ~ack) == '0);
endmodule

// File: rtl/dir_inval_ctrl.sv
// Directory engine for one cache block: full-map presence vector plus an
// exclusive flag. Reads add a sharer; writes invalidate the other sharers
// (invalidate carries the writer ID), reply with the ack count, and grant
// exclusive ownership once all acks have been seen. Requests arriving while
// a round is open are refused via req_busy and must be retried upstream.
module dir_inval_ctrl #(
    parameter  int N_PROC = 4,
    localparam int ID_W   = $clog2(N_PROC),
    localparam int CNT_W  = $clog2(N_PROC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ID_W-1:0]   req_id,
    output logic              req_busy,
    output logic [N_PROC-1:0] inv_valid,
    output logic [ID_W-1:0]   inv_req_id,
    input  logic [N_PROC-1:0] ack_valid,
    output logic              wr_reply_valid,
    output logic [ID_W-1:0]   wr_reply_id,
    output logic [CNT_W-1:0]  wr_reply_acks,
    output logic              grant_valid,
    output logic [ID_W-1:0]   grant_id,
    output logic [N_PROC-1:0] presence,
    output logic              exclusive
);
    import dir_pkg::*;

    localparam logic [N_PROC-1:0] ONE = N_PROC'(1);

    dir_state_e        state;
    logic [ID_W-1:0]   writer;
    logic [N_PROC-1:0] targets;
    logic [CNT_W-1:0]  count;
    logic [N_PROC-1:0] pending;
    logic              last_ack;
    logic              wr_accept;

    dir_target_calc #(.N_PROC(N_PROC), .ID_W(ID_W), .CNT_W(CNT_W)) u_targets (
        .pres    (presence),
        .wid     (req_id),
        .targets (targets),
        .count   (count)
    );

    dir_ack_tracker #(.N_PROC(N_PROC)) u_acks (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_accept),
        .load_mask (targets),
        .ack       (ack_valid),
        .pending   (pending),
        .last_ack  (last_ack)
    );

    // Refuse requests while an invalidation round is open.
    always_comb req_busy = (state == DIR_COLLECT);

    // A write is accepted only when the engine is idle.
    always_comb wr_accept = (state == DIR_IDLE) && req_valid && req_write;

    // Directory state, message pulses and the round sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= DIR_IDLE;
            writer         <= '0;
            presence       <= '0;
            exclusive      <= 1'b0;
            inv_valid      <= '0;
            inv_req_id     <= '0;
            wr_reply_valid <= 1'b0;
            wr_reply_id    <= '0;
            wr_reply_acks  <= '0;
            grant_valid    <= 1'b0;
            grant_id       <= '0;
        end else begin
            inv_valid      <= '0;
            wr_reply_valid <= 1'b0;
            grant_valid    <= 1'b0;
            case (state)
                DIR_IDLE: begin
                    if (req_valid && !req_write) begin
                        presence  <= presence | (ONE << req_id);
                        exclusive <= 1'b0;
                    end else if (wr_accept) begin
                        writer         <= req_id;
                        inv_valid      <= targets;
                        inv_req_id     <= req_id;
                        wr_reply_valid <= 1'b1;
                        wr_reply_id    <= req_id;
                        wr_reply_acks  <= count;
                        if (count == '0) begin
                            grant_valid <= 1'b1;
                            grant_id    <= req_id;
                            presence    <= ONE << req_id;
                            exclusive   <= 1'b1;
                        end else begin
                            state <= DIR_COLLECT;
                        end
                    end
                end
                DIR_COLLECT: begin
                    if (last_ack) begin
                        grant_valid <= 1'b1;
                        grant_id    <= writer;
                        presence    <= ONE << writer;
                        exclusive   <= 1'b1;
                        state       <= DIR_IDLE;
                    end
                end
                default: state <= DIR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dir_inval_chk.sv
// Port-level protocol checker for dir_inval_ctrl, attached by bind below.
module dir_inval_chk #(
    parameter  int N_PROC = 4,
    localparam int ID_W   = $clog2(N_PROC),
    localparam int CNT_W  = $clog2(N_PROC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ID_W-1:0]   req_id,
    input logic              req_busy,
    input logic [N_PROC-1:0] inv_valid,
    input logic [ID_W-1:0]   inv_req_id,
    input logic              wr_reply_valid,
    input logic [CNT_W-1:0]  wr_reply_acks,
    input logic              grant_valid,
    input logic [ID_W-1:0]   grant_id,
    input logic [N_PROC-1:0] presence,
    input logic              exclusive
);
    localparam logic [N_PROC-1:0] ONE = N_PROC'(1);

    // A read accepted while idle leaves the reader present and not exclusive.
    p_read_adds_sharer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_busy) |=> (presence[$past(req_id)] && !exclusive));

    // The writer never invalidates itself.
    p_inv_skips_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|inv_valid) |-> !inv_valid[inv_req_id]);

    // Invalidates only travel with a write-reply whose count matches them.
    p_reply_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reply_valid |-> (wr_reply_acks == CNT_W'($countones(inv_valid))));

    p_inv_with_reply_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|inv_valid) |-> wr_reply_valid);

    // The directory is frozen across busy cycles.
    p_busy_freezes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && $past(req_busy)) |-> $stable(presence));

    // No grant while acknowledgements are still outstanding.
    p_no_grant_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_busy |-> !grant_valid);

    // A grant leaves the owner as the sole, exclusive holder.
    p_grant_sole_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (exclusive && presence == (ONE << grant_id)));
endmodule

bind dir_inval_ctrl dir_inval_chk #(.N_PROC(N_PROC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_id         (req_id),
    .req_busy       (req_busy),
    .inv_valid      (inv_valid),
    .inv_req_id     (inv_req_id),
    .wr_reply_valid (wr_reply_valid),
    .wr_reply_acks  (wr_reply_acks),
    .grant_valid    (grant_valid),
    .grant_id       (grant_id),
    .presence       (presence),
    .exclusive      (exclusive)
);

// File: tb/sim_dir_inval_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_dir_inval_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_id = '0;
    logic       req_busy;
    logic [3:0] inv_valid;
    logic [1:0] inv_req_id;
    logic [3:0] ack_valid = '0;
    logic       wr_reply_valid;
    logic [1:0] wr_reply_id;
    logic [2:0] wr_reply_acks;
    logic       grant_valid;
    logic [1:0] grant_id;
    logic [3:0] presence;
    logic       exclusive;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    dir_inval_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_id(req_id), .req_busy(req_busy), .inv_valid(inv_valid),
        .inv_req_id(inv_req_id), .ack_valid(ack_valid),
        .wr_reply_valid(wr_reply_valid), .wr_reply_id(wr_reply_id),
        .wr_reply_acks(wr_reply_acks), .grant_valid(grant_valid),
        .grant_id(grant_id), .presence(presence), .exclusive(exclusive)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive a request for one clock, sample at the following falling edge.
    task automatic send_req(input logic wr, input logic [1:0] id);
        req_valid = 1'b1; req_write = wr; req_id = id;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Drive an ack vector for one clock, sample at the following falling edge.
    task automatic send_ack(input logic [3:0] a);
        ack_valid = a;
        @(negedge clk);
        ack_valid = '0;
    endtask

    task automatic t_reset;
        chk("R1 presence", presence, 0);
        chk("R1 exclusive", exclusive, 0);
        chk("R1 busy", req_busy, 0);
        chk("R1 pulses", {inv_valid, wr_reply_valid, grant_valid}, 0);
    endtask

    task automatic t_reads;
        send_req(1'b0, 2'd0);
        chk("R2 first read", presence, 4'b0001);
        send_req(1'b0, 2'd1);
        send_req(1'b0, 2'd3);
        chk("R2 three readers", presence, 4'b1011);
        chk("R2 exclusive", exclusive, 0);
    endtask

    task automatic t_write_sharers;
        send_req(1'b1, 2'd1);
        chk("R3 inv set", inv_valid, 4'b1001);
        chk("R3 inv writer id", inv_req_id, 1);
        chk("R4 reply valid", wr_reply_valid, 1);
        chk("R4 reply id", wr_reply_id, 1);
        chk("R4 reply count", wr_reply_acks, 2);
        chk("R5 busy", req_busy, 1);
        chk("R7 no early grant", grant_valid, 0);
        // refused read while busy
        send_req(1'b0, 2'd2);
        chk("R3 inv single pulse", inv_valid, 0);
        chk("R4 reply single pulse", wr_reply_valid, 0);
        chk("R5 refused read", presence, 4'b1011);
        send_req(1'b1, 2'd2);
        chk("R5 refused write inv", inv_valid, 0);
        chk("R5 refused write presence", presence, 4'b1011);
        // ack from non-invalidated cache, then one real, then a repeat
        send_ack(4'b0100);
        chk("R6 stray ack", grant_valid, 0);
        chk("R6 stray busy", req_busy, 1);
        send_ack(4'b0001);
        chk("R6 partial", grant_valid, 0);
        send_ack(4'b0001);
        chk("R6 repeat", grant_valid, 0);
        chk("R6 repeat busy", req_busy, 1);
        send_ack(4'b1000);
        chk("R7 grant", grant_valid, 1);
        chk("R7 grant id", grant_id, 1);
        chk("R7 presence", presence, 4'b0010);
        chk("R7 exclusive", exclusive, 1);
        chk("R7 not busy", req_busy, 0);
        @(negedge clk);
        chk("R7 grant pulse", grant_valid, 0);
    endtask

    task automatic t_write_alone;
        send_req(1'b1, 2'd1);
        chk("R8 no inv", inv_valid, 0);
        chk("R8 reply", wr_reply_valid, 1);
        chk("R8 count zero", wr_reply_acks, 0);
        chk("R8 grant same cycle", grant_valid, 1);
        chk("R8 presence", presence, 4'b0010);
        chk("R8 exclusive", exclusive, 1);
        chk("R8 not busy", req_busy, 0);
    endtask

    task automatic t_write_new_owner;
        send_req(1'b0, 2'd2);
        chk("R2 read clears excl", exclusive, 0);
        chk("R2 read keeps owner", presence, 4'b0110);
        send_req(1'b1, 2'd0);
        chk("R3 inv non-holder writer", inv_valid, 4'b0110);
        chk("R4 count two", wr_reply_acks, 2);
        send_ack(4'b0110);
        chk("R7 both acks grant", grant_valid, 1);
        chk("R7 new owner", presence, 4'b0001);
        chk("R7 new owner id", grant_id, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_reads();
                t_write_sharers();
                t_write_alone();
                t_write_new_owner();
            end
            begin
                repeat (5000) @(negedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule